// File: doc/BRIEF.md
# NAND Logical Block Remap Unit

This block lets a processor boot from NAND parts in which only physical block zero is known to be good. After reset it reads the first page of block zero through a plain byte-wide NAND read interface and keeps the first 32 bytes of that page in a small mapping RAM. Each byte gives the physical block number that holds one 128 KB logical block. Together the 32 entries cover a 4 MB logical code space, so that code space can sit on any set of good physical blocks.

Once the table is loaded the block raises `init_done` and serves address translation in the same cycle. The requester presents a 22-bit logical byte address. The upper five bits select a table entry, and the low 17 bits pass through unchanged as the offset inside the block. A request made before the load has finished gets no acknowledge. The requester keeps the request asserted until `xl_ack` rises.

Strobe timing adapts to the clock through a 4-bit width setting, given in clock cycles. The command, address and read strobes each stay low for that many cycles and then high for the same number of cycles.

Top module: `nand_remap`

## Requirements
- R1: While `rst` is high, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `nand_dq_oe`, `init_done` and `xl_ack` are 0.
- R2: After reset release the block writes exactly seven bytes to the NAND, in this order: command 0x00 with `nand_cle`=1 and `nand_ale`=0, then five address bytes of 0x00 with `nand_ale`=1 and `nand_cle`=0, then command 0x30 with `nand_cle`=1. `nand_dq_out` is valid at each rising edge of `nand_we_n`. `nand_cle` and `nand_ale` are never high together.
- R3: Every low pulse and every high gap of `nand_we_n` and `nand_re_n` inside a byte lasts N clock cycles, where N is the value of `cfg_pulse` sampled when reset is released. A value of 0 selects the default of 3 cycles.
- R4: `nand_re_n` does not fall while `nand_rb_n` is 0 (busy). The first read strobe waits until the NAND reports ready after the 0x30 command.
- R5: Exactly 32 read strobes are issued. The byte on `nand_dq_in` at the k-th rising edge of `nand_re_n` (k = 0..31) becomes table entry k.
- R6: `init_done` rises only after the 32nd read strobe has returned high. After that it stays 1 until reset and no further NAND strobe is issued.
- R7: `xl_pblk` equals table entry `xl_laddr[21:17]`, and `xl_offs` equals `xl_laddr[16:0]`, both combinational in the cycle of the request.
- R8: `xl_ack` is 0 while `init_done` is 0, even with `xl_req` held high. Once `init_done` is 1, `xl_ack` follows `xl_req`.
- R9: A reset asserted in the middle of the table load returns all NAND outputs to idle. On release the whole sequence restarts from the first command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_pulse | input | 4 | Strobe width in cycles, 0 selects 3 |
| nand_rb_n | input | 1 | NAND ready (1) / busy (0) |
| nand_dq_in | input | 8 | NAND data bus, read direction |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | NAND data bus, write direction |
| nand_dq_oe | output | 1 | Drive enable for `nand_dq_out` |
| init_done | output | 1 | Mapping table loaded |
| xl_req | input | 1 | Translation request |
| xl_laddr | input | 22 | Logical byte address |
| xl_ack | output | 1 | Translation valid |
| xl_pblk | output | 8 | Physical block number |
| xl_offs | output | 17 | Offset inside the block |

## Verification
Translation is combinational. The bench therefore drives `xl_laddr` at a falling clock edge and reads `xl_pblk`, `xl_offs` and `xl_ack` 1 ns later, with no clock edge in between. Strobe widths are checked against N clock periods by timing each edge of `nand_we_n` and `nand_re_n` in the NAND model. The model also records each latched byte at the rising edge of `nand_we_n` and feeds a new data byte at each falling edge of `nand_re_n`, so the checks follow the design's own pace and no fixed cycle count is assumed. `init_done` is read just after the 32nd read strobe falls, where it must still be 0. It is read again once it rises, and the bench then confirms that no further strobe appears during an idle window.

// File: rtl/nand_remap.sv
module nand_remap #(
  parameter int unsigned ENTRIES    = 32,
  parameter int unsigned EW         = 8,
  parameter int unsigned OFFW       = 17,
  parameter int unsigned PW         = 4,
  parameter int unsigned PW_DEF     = 3,
  parameter int unsigned ADDR_BYTES = 5,
  parameter int unsigned WB_CYC     = 4,
  parameter logic [7:0]  CMD_RD     = 8'h00,
  parameter logic [7:0]  CMD_GO     = 8'h30
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [PW-1:0]                      cfg_pulse,
  input  logic                               nand_rb_n,
  input  logic [7:0]                         nand_dq_in,
  output logic                               nand_ce_n,
  output logic                               nand_cle,
  output logic                               nand_ale,
  output logic                               nand_we_n,
  output logic                               nand_re_n,
  output logic [7:0]                         nand_dq_out,
  output logic                               nand_dq_oe,
  output logic                               init_done,
  input  logic                               xl_req,
  input  logic [$clog2(ENTRIES)+OFFW-1:0]    xl_laddr,
  output logic                               xl_ack,
  output logic [EW-1:0]                      xl_pblk,
  output logic [OFFW-1:0]                    xl_offs
);
  localparam int unsigned IW  = $clog2(ENTRIES);
  localparam int unsigned LAW = IW + OFFW;
  localparam int unsigned ABW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int unsigned WBW = $clog2(WB_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_TWB, S_BUSY, S_READ, S_DONE
  } st_t;

  st_t            st;
  logic [PW-1:0]  wid, cnt;
  logic           ph;
  logic [ABW-1:0] abyte;
  logic [IW-1:0]  idx;
  logic [WBW-1:0] wcnt;
  logic           rb_s1, rb_s2;
  logic [EW-1:0]  map [ENTRIES];
  logic [PW:0]    lowcnt;

  wire strobing = (st == S_CMD1) || (st == S_ADDR) || (st == S_CMD2) || (st == S_READ);
  wire step     = strobing && (cnt == wid - 1'b1);
  wire byte_end = step && ph;
  wire capture  = step && !ph && (st == S_READ);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st    <= S_IDLE;
      wid   <= PW'(PW_DEF);
      cnt   <= '0;
      ph    <= 1'b0;
      abyte <= '0;
      idx   <= '0;
      wcnt  <= '0;
    end else begin
      if (strobing) begin
        if (step) begin
          cnt <= '0;
          ph  <= !ph;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      case (st)
        S_IDLE: begin
          wid <= (cfg_pulse == '0) ? PW'(PW_DEF) : cfg_pulse;
          cnt <= '0;
          ph  <= 1'b0;
          st  <= S_CMD1;
        end
        S_CMD1: if (byte_end) begin
          abyte <= '0;
          st    <= S_ADDR;
        end
        S_ADDR: if (byte_end) begin
          if (abyte == ABW'(ADDR_BYTES - 1)) st <= S_CMD2;
          else abyte <= abyte + 1'b1;
        end
        S_CMD2: if (byte_end) begin
          wcnt <= '0;
          st   <= S_TWB;
        end
        S_TWB: begin
          if (wcnt == WBW'(WB_CYC - 1)) st <= S_BUSY;
          else wcnt <= wcnt + 1'b1;
        end
        S_BUSY: if (rb_s2) begin
          idx <= '0;
          cnt <= '0;
          ph  <= 1'b0;
          st  <= S_READ;
        end
        S_READ: if (byte_end) begin
          if (idx == IW'(ENTRIES - 1)) st <= S_DONE;
          else idx <= idx + 1'b1;
        end
        default: st <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rb_s1 <= 1'b0;
      rb_s2 <= 1'b0;
    end else begin
      rb_s1 <= nand_rb_n;
      rb_s2 <= rb_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) map[idx] <= nand_dq_in;
  end

  assign nand_ce_n   = (st == S_IDLE) || (st == S_DONE);
  assign nand_cle    = (st == S_CMD1) || (st == S_CMD2);
  assign nand_ale    = (st == S_ADDR);
  assign nand_we_n   = !((nand_cle || nand_ale) && !ph);
  assign nand_re_n   = !((st == S_READ) && !ph);
  assign nand_dq_oe  = nand_cle || nand_ale;
  assign nand_dq_out = (st == S_CMD2) ? CMD_GO : (st == S_CMD1) ? CMD_RD : 8'h00;

  assign init_done = (st == S_DONE);
  assign xl_ack    = xl_req && init_done;
  assign xl_pblk   = map[xl_laddr[LAW-1:OFFW]];
  assign xl_offs   = xl_laddr[OFFW-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) lowcnt <= '0;
    else if (!nand_we_n || !nand_re_n) lowcnt <= lowcnt + 1'b1;
    else lowcnt <= '0;
  end

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  p_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
    lowcnt <= {1'b0, wid});

  p_no_read_busy_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(nand_re_n) && $past(st) == S_BUSY) |-> $past(rb_s2));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_quiet_after_r6: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (nand_we_n && nand_re_n && nand_ce_n));

  p_ack_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
    xl_ack |-> xl_req);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

endmodule

// File: tb/sim_nand_remap.sv
`timescale 1ns/1ps
module sim_nand_remap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_pulse = 4'd0;
  logic        nand_rb_n = 1'b1;
  logic [7:0]  nand_dq_in = 8'h00;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic        init_done, xl_req = 1'b0, xl_ack;
  logic [21:0] xl_laddr = '0;
  logic [7:0]  xl_pblk;
  logic [16:0] xl_offs;

  always #2.5 clk = ~clk;

  nand_remap u0 (
    .clk(clk), .rst(rst), .cfg_pulse(cfg_pulse), .nand_rb_n(nand_rb_n),
    .nand_dq_in(nand_dq_in), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .init_done(init_done),
    .xl_req(xl_req), .xl_laddr(xl_laddr), .xl_ack(xl_ack),
    .xl_pblk(xl_pblk), .xl_offs(xl_offs)
  );

  int nchk = 0, nfail = 0;
  int nlat = 0, nre = 0, badwid = 0, rebusy = 0, seed = 0;
  real exp_w = 15.0;
  realtime tw, tr, twh, trh;
  logic [7:0] lat_b [16];
  logic [1:0] lat_k [16];
  logic busy_kick = 1'b0;

  function automatic logic [7:0] tbl(int s, int i);
    return 8'((i * 53 + s * 17 + 11) ^ (s << 2));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit wid_ok(realtime d);
    return (d > exp_w - 0.1) && (d < exp_w + 0.1);
  endfunction

  always @(negedge nand_we_n) if (!rst) begin
    if (nlat > 0 && !wid_ok($realtime - twh)) badwid++;
    tw = $realtime;
  end
  always @(posedge nand_we_n) if (!rst) begin
    if (!wid_ok($realtime - tw)) badwid++;
    twh = $realtime;
    if (nlat < 16) begin
      lat_b[nlat] = nand_dq_out;
      lat_k[nlat] = {nand_cle, nand_ale};
    end
    nlat++;
    if (nand_cle && nand_dq_out == 8'h30) busy_kick = 1'b1;
  end
  always @(posedge busy_kick) begin
    #2 nand_rb_n = 1'b0;
    #200 nand_rb_n = 1'b1;
    busy_kick = 1'b0;
  end
  always @(negedge nand_re_n) if (!rst) begin
    if (!nand_rb_n) rebusy++;
    if (nre > 0 && !wid_ok($realtime - trh)) badwid++;
    tr = $realtime;
    nand_dq_in = tbl(seed, nre % 32);
    nre++;
  end
  always @(posedge nand_re_n) if (!rst) begin
    if (!wid_ok($realtime - tr)) badwid++;
    trh = $realtime;
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #500000;
    nfail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic start_load(int s, logic [3:0] w);
    rst = 1'b1;
    seed = s;
    cfg_pulse = w;
    exp_w = 5.0 * ((w == 0) ? 3 : w);
    repeat (3) @(posedge clk);
    @(negedge clk);
    nlat = 0; nre = 0; badwid = 0; rebusy = 0;
    chk("R1 ce_n", nand_ce_n, 1);
    chk("R1 we_n/re_n", {nand_we_n, nand_re_n}, 2'b11);
    chk("R1 cle/ale/oe", {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk("R1 init_done/ack", {init_done, xl_ack}, 0);
    rst = 1'b0;
  endtask

  task automatic t_full_load(int s, logic [3:0] w);
    int held;
    start_load(s, w);
    xl_req = 1'b1;
    held = 0;
    while (nre < 32) begin
      @(negedge clk);
      if (xl_ack) held++;
    end
    #1 chk("R6 done before last strobe", init_done, 0);
    while (!init_done) begin
      @(negedge clk);
      if (xl_ack && !init_done) held++;
    end
    chk("R8 ack held off", held, 0);
    chk("R2 byte count", nlat, 7);
    for (int i = 0; i < 7; i++) begin
      chk("R2 latch kind", lat_k[i], (i == 0 || i == 6) ? 2'b10 : 2'b01);
      chk("R2 latch byte", lat_b[i], (i == 6) ? 8'h30 : 8'h00);
    end
    chk("R3 strobe widths", badwid, 0);
    chk("R4 read while busy", rebusy, 0);
    chk("R5 read count", nre, 32);
    repeat (40) @(negedge clk);
    chk("R6 quiet after done", nre + nlat, 39);
    chk("R6 done sticky", init_done, 1);
    t_translate(s);
    xl_req = 1'b0;
    #1 chk("R8 ack follows req", xl_ack, 0);
  endtask

  task automatic t_translate(int s);
    for (int i = 0; i < 32; i++) begin
      logic [16:0] off;
      off = 17'((i * 4099 + s * 77) ^ 17'h1A5C3);
      @(negedge clk);
      xl_laddr = {5'(i), off};
      #1;
      chk("R7 pblk", xl_pblk, tbl(s, i));
      chk("R7 offs", xl_offs, off);
      chk("R8 ack", xl_ack, 1);
    end
  endtask

  task automatic t_reset_midload();
    start_load(9, 4'd2);
    wait (nlat >= 3);
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk("R9 idle we/re/ce", {nand_we_n, nand_re_n, nand_ce_n}, 3'b111);
    chk("R9 idle cle/ale", {nand_cle, nand_ale}, 0);
    t_full_load(21, 4'd2);
  endtask

  initial begin
    t_full_load(1, 4'd0);
    t_full_load(2, 4'd1);
    t_full_load(3, 4'd6);
    t_reset_midload();
    finish_up();
  end
endmodule